// File: doc/BRIEF.md
# Frame Clock Ratio Monitor with Soft Mute

This block runs in the master-clock domain. It watches an audio frame clock that arrives without a fixed phase relation to that domain. It counts master-clock cycles between rising frame-clock edges and sorts each measured period into one of three accepted ratios: 256, 384 or 512 master cycles per frame. Any other period counts as a fault, and so does the absence of frame edges.

The block drives a 16-bit gain word that multiplies the audio samples downstream. On a fault the gain ramps down to zero in even steps. A fault is a bad period, a lost frame clock, or a switch from one accepted ratio to another. Once a ratio has been measured the same in two frames in a row, the gain ramps back up to full scale. A full ramp takes 64 steps in either direction. While frames arrive, the gain takes one step per frame. With no frame clock, an internal 1024-cycle timeout paces the steps instead, so muting still completes.

Top module: `clk_ratio_mute`

## Requirements
- R1: After reset, gain is 0, ratio_ok is 0, ratio_code is 0 and ramp_state is 0 (muted).
- R2: A frame period is accepted only if it is exactly 256, 384 or 512 master cycles. These are reported on ratio_code as 1, 2 and 3. Code 0 means no accepted ratio. Any other period never raises ratio_ok.
- R3: ratio_ok rises only at a frame edge whose measured period is valid and equal to the period measured at the previous frame edge. Alternating valid periods never raise it.
- R4: From the muted state with ratio_ok high, ramp_state becomes ramp-up (1). The gain then rises by 1024 at each following frame edge, saturating at 65535. On reaching 65535, ramp_state becomes running (2). The rise takes 64 frames.
- R5: A measured period that differs from the accepted one drops ratio_ok and returns ratio_code to 0 at that frame edge. A valid period of another value counts as such a difference. One cycle later, a running or ramping-up block enters ramp-down (3).
- R6: In ramp-down, the gain falls by 1024 per step and clamps at 0, where ramp_state returns to muted. Ramp-down always runs to zero, even if ratio_ok returns meanwhile. Only then does ramp-up start.
- R7: When 1024 master cycles pass with no frame edge, ratio_ok drops. From then on, a step is taken every 1024 cycles, so the gain still ramps to 0.
- R8: After a frame-clock loss, the first new frame edge only restarts measurement. Acceptance then follows the rule of R3.
- R9: The gain is 0 whenever muted and 65535 whenever running. It rises only in a cycle following one where ratio_ok was high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_clk | input | 1 | Asynchronous frame clock; rising edges delimit frames |
| ratio_code | output | 2 | Accepted ratio: 0 none, 1 = 256, 2 = 384, 3 = 512 |
| ratio_ok | output | 1 | High while an accepted ratio holds |
| gain | output | 16 | Gain word applied to the audio samples |
| ramp_state | output | 2 | 0 muted, 1 ramp-up, 2 running, 3 ramp-down |

## Verification
A frame-clock rise driven before master edge k passes two synchroniser flops and an edge register, so ratio_ok, ratio_code and any gain step take effect at edge k+2. ramp_state follows a change of ratio_ok one edge after that. The bench drives every frame edge on a falling master edge and samples only at the end of each whole frame, hundreds of cycles after the last effect is due. In loss tests, the timeout steps land at k+2+1024·j, and the samples sit well between two such steps.

// File: rtl/crm_pkg.sv
// Package: shared encodings for the clock ratio monitor.
// Assumes: ratio and state codes are observed at the top ports as 2-bit values.
package crm_pkg;

    typedef enum logic [1:0] {
        RC_NONE = 2'd0,
        RC_256  = 2'd1,
        RC_384  = 2'd2,
        RC_512  = 2'd3
    } ratio_code_t;

    typedef enum logic [1:0] {
        ST_MUTED     = 2'd0,
        ST_RAMP_UP   = 2'd1,
        ST_RUNNING   = 2'd2,
        ST_RAMP_DOWN = 2'd3
    } ramp_state_t;

    // Maps a measured period in master cycles to its ratio code.
    function automatic ratio_code_t classify_period(input int unsigned cycles);
        case (cycles)
            256:     return RC_256;
            384:     return RC_384;
            512:     return RC_512;
            default: return RC_NONE;
        endcase
    endfunction

endpackage

// File: rtl/crm_frame_sync.sv
// Module: crm_frame_sync
// Brings the asynchronous frame clock into the master domain through STAGES flops,
// then flags each rising edge with a single-cycle pulse.
// Assumes: frame clock high and low phases each last at least two master cycles.
module crm_frame_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_in,
    output logic rise
);
    logic [STAGES-1:0] pipe;
    logic              last;

    // Synchroniser chain plus one register for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= '0;
            last <= 1'b0;
        end else begin
            pipe <= {pipe[STAGES-2:0], frame_in};
            last <= pipe[STAGES-1];
        end
    end

    // A rising edge shows as new high after old low.
    assign rise = pipe[STAGES-1] & ~last;
endmodule

// File: rtl/crm_period_meter.sv
// Module: crm_period_meter
// Counts master cycles between frame edges, classifies each full period and issues
// a timeout pulse every LOSS_LIMIT cycles with no edge.
// Assumes: the first edge after reset or after a timeout only arms the measurement.
module crm_period_meter
    import crm_pkg::*;
#(
    parameter int LOSS_LIMIT = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rise,
    output logic        meas_stb,
    output ratio_code_t meas_code,
    output logic        timeout
);
    localparam int CNT_W = $clog2(LOSS_LIMIT + 1);
    localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LOSS_LIMIT);

    logic [CNT_W-1:0] cnt;
    logic             armed;

    // Timeout fires when the count hits the limit with no edge in this cycle.
    assign timeout   = !rise && (cnt == LIMIT_V);
    assign meas_stb  = rise && armed;
    assign meas_code = classify_period(32'(cnt));

    // Period counter: restarts on each edge and on each timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= CNT_W'(1);
            armed <= 1'b0;
        end else if (rise) begin
            cnt   <= CNT_W'(1);
            armed <= 1'b1;
        end else if (timeout) begin
            cnt   <= CNT_W'(1);
            armed <= 1'b0;
        end else begin
            cnt   <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/crm_ratio_qualifier.sv
// Module: crm_ratio_qualifier
// Accepts a ratio after two consecutive equal valid measurements. Drops it on any
// differing measurement or on a timeout.
// Assumes: meas_stb and timeout are never high together.
module crm_ratio_qualifier
    import crm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        meas_stb,
    input  ratio_code_t meas_code,
    input  logic        timeout,
    output logic        ok,
    output ratio_code_t cur_code
);
    ratio_code_t prev_code;

    // Acceptance state: update on measurements, clear on clock loss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ok        <= 1'b0;
            cur_code  <= RC_NONE;
            prev_code <= RC_NONE;
        end else if (timeout) begin
            ok        <= 1'b0;
            cur_code  <= RC_NONE;
            prev_code <= RC_NONE;
        end else if (meas_stb) begin
            prev_code <= meas_code;
            if (ok) begin
                if (meas_code != cur_code) begin
                    ok       <= 1'b0;
                    cur_code <= RC_NONE;
                end
            end else if (meas_code != RC_NONE && meas_code == prev_code) begin
                ok       <= 1'b1;
                cur_code <= meas_code;
            end
        end
    end
endmodule

// File: rtl/crm_gain_ramp.sv
// Module: crm_gain_ramp
// Four-state ramp controller. Steps the gain by a fixed amount on each tick, so a full
// ramp takes RAMP_STEPS ticks. Ramp-down always completes before ramp-up begins.
// Assumes: tick is a single-cycle pulse.
module crm_gain_ramp
    import crm_pkg::*;
#(
    parameter int GAIN_W     = 16,
    parameter int RAMP_STEPS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ok,
    input  logic              tick,
    output ramp_state_t       state,
    output logic [GAIN_W-1:0] gain
);
    localparam logic [GAIN_W-1:0] FULL = {GAIN_W{1'b1}};
    localparam logic [GAIN_W:0]   STEP = (GAIN_W+1)'((2 ** GAIN_W) / RAMP_STEPS);

    ramp_state_t       state_nx;
    logic [GAIN_W-1:0] gain_nx;
    logic [GAIN_W:0]   up_sum;

    assign up_sum = {1'b0, gain} + STEP;

    // Next-state and next-gain selection.
    always_comb begin
        state_nx = state;
        gain_nx  = gain;
        case (state)
            ST_MUTED: begin
                if (ok) state_nx = ST_RAMP_UP;
            end
            ST_RAMP_UP: begin
                if (!ok) begin
                    state_nx = ST_RAMP_DOWN;
                end else if (tick) begin
                    if (up_sum >= {1'b0, FULL}) begin
                        gain_nx  = FULL;
                        state_nx = ST_RUNNING;
                    end else begin
                        gain_nx = up_sum[GAIN_W-1:0];
                    end
                end
            end
            ST_RUNNING: begin
                if (!ok) state_nx = ST_RAMP_DOWN;
            end
            ST_RAMP_DOWN: begin
                if (tick) begin
                    if ({1'b0, gain} <= STEP) begin
                        gain_nx  = '0;
                        state_nx = ST_MUTED;
                    end else begin
                        gain_nx = gain - STEP[GAIN_W-1:0];
                    end
                end
            end
            default: state_nx = ST_MUTED;
        endcase
    end

    // State and gain registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_MUTED;
            gain  <= '0;
        end else begin
            state <= state_nx;
            gain  <= gain_nx;
        end
    end
endmodule

// File: rtl/clk_ratio_mute.sv
// Module: clk_ratio_mute (top)
// Measures the master-to-frame clock ratio, qualifies it, and drives a soft mute gain.
// Steps come from frame edges, or from the loss timeout when frames stop.
// Assumes: frame_clk is asynchronous to clk; reset is synchronous, active low.
module clk_ratio_mute
    import crm_pkg::*;
#(
    parameter int GAIN_W      = 16,
    parameter int RAMP_STEPS  = 64,
    parameter int LOSS_LIMIT  = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_clk,
    output logic [1:0]        ratio_code,
    output logic              ratio_ok,
    output logic [GAIN_W-1:0] gain,
    output logic [1:0]        ramp_state
);
    logic        rise;
    logic        meas_stb;
    logic        timeout;
    ratio_code_t meas_code;
    ratio_code_t cur_code;
    ramp_state_t st;

    crm_frame_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_in (frame_clk),
        .rise     (rise)
    );

    crm_period_meter #(.LOSS_LIMIT(LOSS_LIMIT)) u_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise      (rise),
        .meas_stb  (meas_stb),
        .meas_code (meas_code),
        .timeout   (timeout)
    );

    crm_ratio_qualifier u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .meas_stb  (meas_stb),
        .meas_code (meas_code),
        .timeout   (timeout),
        .ok        (ratio_ok),
        .cur_code  (cur_code)
    );

    crm_gain_ramp #(.GAIN_W(GAIN_W), .RAMP_STEPS(RAMP_STEPS)) u_ramp (
        .clk   (clk),
        .rst_n (rst_n),
        .ok    (ratio_ok),
        .tick  (rise | timeout),
        .state (st),
        .gain  (gain)
    );

    assign ratio_code = cur_code;
    assign ramp_state = st;
endmodule

// File: rtl/clk_ratio_mute_chk.sv
// Module: clk_ratio_mute_chk
// Property checker for clk_ratio_mute, bound to every instance of the top.
// Assumes: ramp_state uses the crm_pkg state encoding.
module clk_ratio_mute_chk
    import crm_pkg::*;
#(
    parameter int GAIN_W     = 16,
    parameter int RAMP_STEPS = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        ratio_code,
    input logic              ratio_ok,
    input logic [GAIN_W-1:0] gain,
    input logic [1:0]        ramp_state
);
    localparam logic [GAIN_W-1:0] FULL = {GAIN_W{1'b1}};
    localparam logic [GAIN_W-1:0] STEP = GAIN_W'((2 ** GAIN_W) / RAMP_STEPS);

    // R9
    gain_zero_muted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_state == ST_MUTED) |-> (gain == '0));

    // R9
    gain_full_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_state == ST_RUNNING) |-> (gain == FULL));

    // R4
    gain_step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gain > $past(gain)) |-> ((gain - $past(gain)) <= STEP));

    // R9
    gain_rise_needs_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gain > $past(gain)) |-> $past(ratio_ok));

    // R5
    mute_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_state == ST_RUNNING && !ratio_ok) |=> (ramp_state == ST_RAMP_DOWN));

    // R2
    code_when_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_ok |-> (ratio_code != RC_NONE));

    // R5
    code_when_not_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ratio_ok |-> (ratio_code == RC_NONE));

    // R6
    down_until_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_state == ST_RAMP_DOWN && gain != '0) |=> (ramp_state != ST_RAMP_UP));
endmodule

bind clk_ratio_mute clk_ratio_mute_chk #(
    .GAIN_W     (GAIN_W),
    .RAMP_STEPS (RAMP_STEPS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ratio_code (ratio_code),
    .ratio_ok   (ratio_ok),
    .gain       (gain),
    .ramp_state (ramp_state)
);

// File: tb/clk_ratio_mute_test.sv
// Bench: directed scenarios, one task each, sampling at the end of whole frames.
module clk_ratio_mute_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_clk = 1'b0;
    logic [1:0]  ratio_code;
    logic        ratio_ok;
    logic [15:0] gain;
    logic [1:0]  ramp_state;

    int checks = 0;
    int errors = 0;

    clk_ratio_mute uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_clk  (frame_clk),
        .ratio_code (ratio_code),
        .ratio_ok   (ratio_ok),
        .gain       (gain),
        .ramp_state (ramp_state)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One frame of n master cycles, starting and ending on a falling edge.
    task automatic frame(input int n);
        frame_clk = 1'b1;
        repeat (n / 2) @(negedge clk);
        frame_clk = 1'b0;
        repeat (n - n / 2) @(negedge clk);
    endtask

    task automatic frames(input int n, input int count);
        for (int i = 0; i < count; i++) frame(n);
    endtask

    task automatic t_reset;
        chk("R1 gain", gain, 0);
        chk("R1 ok", ratio_ok, 0);
        chk("R1 code", ratio_code, 0);
        chk("R1 state", ramp_state, 0);
    endtask

    task automatic t_bad_ratio;
        frames(300, 6);
        chk("R2 ok on 300", ratio_ok, 0);
        chk("R2 gain on 300", gain, 0);
    endtask

    task automatic t_alternating;
        for (int i = 0; i < 3; i++) begin
            frame(256);
            frame(384);
        end
        chk("R3 ok alternating", ratio_ok, 0);
        chk("R3 state alternating", ramp_state, 0);
    endtask

    task automatic t_accept_ramp_up;
        frames(256, 2);
        chk("R3 ok after one match", ratio_ok, 0);
        frames(256, 1);
        chk("R3 ok confirmed", ratio_ok, 1);
        chk("R2 code 256", ratio_code, 1);
        chk("R4 state ramp-up", ramp_state, 1);
        chk("R4 gain before step", gain, 0);
        frames(256, 1);
        chk("R4 first step", gain, 1024);
        frames(256, 31);
        chk("R4 mid ramp", gain, 32768);
        frames(256, 32);
        chk("R4 full gain", gain, 65535);
        chk("R4 running", ramp_state, 2);
    endtask

    task automatic t_ratio_change;
        frames(384, 1);
        chk("R5 old period still ok", ratio_ok, 1);
        chk("R5 gain held", gain, 65535);
        frames(384, 1);
        chk("R5 ok dropped", ratio_ok, 0);
        chk("R5 code cleared", ratio_code, 0);
        chk("R5 ramp-down entered", ramp_state, 3);
        chk("R5 no step yet", gain, 65535);
        frames(384, 1);
        chk("R6 new ratio accepted", ratio_code, 2);
        chk("R6 still ramping down", ramp_state, 3);
        chk("R6 first down step", gain, 64511);
        frames(384, 62);
        chk("R6 near zero", gain, 1023);
        frames(384, 1);
        chk("R6 clamped zero", gain, 0);
        chk("R6 restarted ramp-up", ramp_state, 1);
        frames(384, 64);
        chk("R4 full again at 384", gain, 65535);
        chk("R4 running at 384", ramp_state, 2);
    endtask

    task automatic t_clock_loss;
        repeat (700) @(negedge clk);
        chk("R7 ok dropped on loss", ratio_ok, 0);
        chk("R7 ramp-down on loss", ramp_state, 3);
        chk("R7 no step at first timeout", gain, 65535);
        repeat (32 * 1024) @(negedge clk);
        chk("R7 timed steps", gain, 32767);
        repeat (32 * 1024) @(negedge clk);
        chk("R7 muted after loss", gain, 0);
        chk("R7 muted state", ramp_state, 0);
    endtask

    task automatic t_recover;
        frames(512, 2);
        chk("R8 not yet accepted", ratio_ok, 0);
        frames(512, 1);
        chk("R8 accepted", ratio_ok, 1);
        chk("R8 code 512", ratio_code, 3);
        frames(512, 1);
        chk("R8 first step", gain, 1024);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_bad_ratio;
        t_alternating;
        t_accept_ramp_up;
        t_ratio_change;
        t_clock_loss;
        t_recover;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule